// File: doc/BRIEF.md
# Hart-Local Interrupt Cause Controller

This block sits beside one processor core and turns three raw interrupt lines into a single trap request plus a cause word. The three lines are a software line, a timer line and an external line. The software line is the only path for one core to signal another. The external line is the only path by which device interrupts reach the core. Each line is captured into a pending register. A software-visible enable register masks the pending bits. When the core's global interrupt enable is high and any enabled line is pending, the block raises a trap request.

When the core accepts the request, the block latches a cause word. The top bit of the cause word marks it as an interrupt rather than an exception. The low bits carry the code of the winning source. If several enabled sources are pending together, the external line wins, then the software line, then the timer line.

Software reaches the enable and pending registers through a small control-register port. The port supports read, write, bit-set and bit-clear operations. The pending register cannot be written, because the hardware lines drive it.

Top module: `hart_irq_ctrl`

## Requirements
- R1: After reset, the enable register, the pending register and the cause output all read zero, and `trap_req` is low.
- R2: With `csr_sel`=0, `csr_rdata` shows the enable register, zero-extended to XLEN. Only bits 1 (software), 5 (timer) and 9 (external) can be written; every other bit always reads 0. Operation code 1 (write) replaces the register with `csr_wdata` masked to those three bits.
- R3: With `csr_sel`=0, operation code 2 (set) ORs the masked `csr_wdata` into the enable register. Operation code 3 (clear) removes the masked bits from it. Operation code 0 (read) leaves it unchanged. Every update takes effect at the clock edge where `csr_en` is high.
- R4: With `csr_sel`=1, `csr_rdata` shows the pending register. Bit 1 is `irq_sw`, bit 5 is `irq_tmr` and bit 9 is `irq_ext`, each as sampled at the previous clock edge. All other bits read 0. Write, set and clear operations aimed at this register have no effect.
- R5: `trap_req` is high exactly when `glb_ie` is high and the bitwise AND of the pending and enable registers is non-zero.
- R6: When more than one enabled source is pending, the cause code is chosen in this order: 9 (external), then 1 (software), then 5 (timer).
- R7: At a clock edge where `trap_ack` and `trap_req` are both high, `trap_cause` loads a value whose bit XLEN-1 is 1 and whose low bits hold the winning code. At all other times it holds its value. XLEN may be 32 or 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_ie | input | 1 | Global interrupt enable from the core |
| irq_sw | input | 1 | Software (inter-processor) interrupt line |
| irq_tmr | input | 1 | Timer interrupt line |
| irq_ext | input | 1 | External device interrupt line |
| csr_en | input | 1 | Register access strobe |
| csr_op | input | 2 | 0 read, 1 write, 2 set bits, 3 clear bits |
| csr_sel | input | 1 | 0 selects the enable register, 1 selects the pending register |
| csr_wdata | input | XLEN | Write, set or clear operand |
| csr_rdata | output | XLEN | Read data from the selected register |
| trap_ack | input | 1 | Core accepts the current trap request |
| trap_req | output | 1 | Interrupt trap request to the core |
| trap_cause | output | XLEN | Latched cause word: interrupt flag in the top bit, code in the low bits |

## Verification
The assertions take all inputs to be synchronous to `clk`. They expect `trap_ack` to matter only while `trap_req` is high. They also expect the raw lines to be level signals that may change on any cycle. The stimulus changes every input only at the falling edge, so each rising edge sees stable values. The random phase raises `trap_ack` freely, including when no request is present, to show that a stray accept leaves the cause word untouched. Directed sequences force all three sources to be pending at once and then drop them one by one to walk through the priority order.

// File: rtl/hic_pkg.sv
package hic_pkg;

    // Register operations on the control port
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } csr_op_e;

    // Span of the enable/pending registers; the top source sits at bit 9
    localparam int SRC_W = 10;
    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] CODE_SW  = 4'd1;
    localparam logic [CODE_W-1:0] CODE_TMR = 4'd5;
    localparam logic [CODE_W-1:0] CODE_EXT = 4'd9;

    localparam logic [SRC_W-1:0] LIVE_MASK = 10'h222;

    typedef struct packed {
        logic ext;
        logic tmr;
        logic sw;
    } irq_lines_t;

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
    } pick_t;

    // Put the three lines at their architectural bit positions
    function automatic logic [SRC_W-1:0] place_lines(irq_lines_t l);
        logic [SRC_W-1:0] v;
        v = '0;
        v[CODE_SW]  = l.sw;
        v[CODE_TMR] = l.tmr;
        v[CODE_EXT] = l.ext;
        return v;
    endfunction

    // Fixed priority: external, then software, then timer
    function automatic pick_t choose(logic [SRC_W-1:0] live);
        pick_t p;
        p.valid = 1'b1;
        if (live[CODE_EXT])      p.code = CODE_EXT;
        else if (live[CODE_SW])  p.code = CODE_SW;
        else if (live[CODE_TMR]) p.code = CODE_TMR;
        else begin
            p.valid = 1'b0;
            p.code  = '0;
        end
        return p;
    endfunction

endpackage

// File: rtl/hic_pending_reg.sv
module hic_pending_reg
    import hic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  irq_lines_t       lines,
    output logic [SRC_W-1:0] pend_q
);
    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= place_lines(lines);
    end
endmodule

// File: rtl/hic_enable_reg.sv
module hic_enable_reg
    import hic_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  csr_op_e          op,
    input  logic [XLEN-1:0]  wdata,
    output logic [SRC_W-1:0] en_q
);
    logic [SRC_W-1:0] operand;
    logic [SRC_W-1:0] en_d;

    assign operand = wdata[SRC_W-1:0] & LIVE_MASK;

    always_comb begin
        en_d = en_q;
        if (wr_en) begin
            unique case (op)
                OP_WRITE: en_d = operand;
                OP_SET:   en_d = en_q | operand;
                OP_CLEAR: en_d = en_q & ~operand;
                default:  en_d = en_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_d;
    end
endmodule

// File: rtl/hic_arbiter.sv
module hic_arbiter
    import hic_pkg::*;
(
    input  logic             glb_ie,
    input  logic [SRC_W-1:0] pend,
    input  logic [SRC_W-1:0] en,
    output logic             req,
    output pick_t            winner
);
    logic [SRC_W-1:0] live;

    assign live   = pend & en & LIVE_MASK;
    assign winner = choose(live);
    assign req    = glb_ie & winner.valid;
endmodule

// File: rtl/hic_cause_reg.sv
module hic_cause_reg
    import hic_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  pick_t           winner,
    output logic [XLEN-1:0] cause_q
);
    localparam int FILL_W = XLEN - 1 - CODE_W;

    always_ff @(posedge clk) begin
        if (rst)       cause_q <= '0;
        else if (take) cause_q <= {1'b1, {FILL_W{1'b0}}, winner.code};
    end
endmodule

// File: rtl/hart_irq_ctrl.sv
module hart_irq_ctrl
    import hic_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            glb_ie,
    input  logic            irq_sw,
    input  logic            irq_tmr,
    input  logic            irq_ext,
    input  logic            csr_en,
    input  logic [1:0]      csr_op,
    input  logic            csr_sel,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    input  logic            trap_ack,
    output logic            trap_req,
    output logic [XLEN-1:0] trap_cause
);
    localparam int PAD_W = XLEN - SRC_W;

    irq_lines_t       lines;
    logic [SRC_W-1:0] pend_q;
    logic [SRC_W-1:0] en_q;
    pick_t            winner;
    logic             take;

    assign lines = '{ext: irq_ext, tmr: irq_tmr, sw: irq_sw};

    hic_pending_reg pend_i (
        .clk    (clk),
        .rst    (rst),
        .lines  (lines),
        .pend_q (pend_q)
    );

    hic_enable_reg #(.XLEN(XLEN)) en_i (
        .clk   (clk),
        .rst   (rst),
        .wr_en (csr_en & ~csr_sel),
        .op    (csr_op_e'(csr_op)),
        .wdata (csr_wdata),
        .en_q  (en_q)
    );

    hic_arbiter arb_i (
        .glb_ie (glb_ie),
        .pend   (pend_q),
        .en     (en_q),
        .req    (trap_req),
        .winner (winner)
    );

    assign take = trap_req & trap_ack;

    hic_cause_reg #(.XLEN(XLEN)) cause_i (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .winner  (winner),
        .cause_q (trap_cause)
    );

    assign csr_rdata = {{PAD_W{1'b0}}, (csr_sel ? pend_q : en_q)};
endmodule

// File: rtl/hart_irq_ctrl_chk.sv
module hart_irq_ctrl_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            glb_ie,
    input logic            irq_ext,
    input logic            csr_en,
    input logic [1:0]      csr_op,
    input logic            csr_sel,
    input logic            trap_ack,
    input logic            trap_req,
    input logic [9:0]      en_q,
    input logic [9:0]      pend_q,
    input logic [XLEN-1:0] trap_cause
);
    // R5: a request needs the global enable and an enabled pending source
    a_r5_req_gated: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (glb_ie && ((en_q & pend_q) != 10'd0)));

    // R7: the cause word only moves on an accepted request
    a_r7_cause_hold: assert property (@(posedge clk) disable iff (rst)
        !(trap_ack && trap_req) |=> $stable(trap_cause));

    // R7: an accepted request leaves the interrupt flag set
    a_r7_cause_flag: assert property (@(posedge clk) disable iff (rst)
        (trap_ack && trap_req) |=> trap_cause[XLEN-1]);

    // R6: an enabled pending external source always wins
    a_r6_ext_wins: assert property (@(posedge clk) disable iff (rst)
        (trap_ack && trap_req && en_q[9] && pend_q[9]) |=> (trap_cause[3:0] == 4'd9));

    // R4: the external pending bit follows its line by one cycle
    a_r4_pend_tracks: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pend_q[9] == $past(irq_ext)));

    // R3: a read access leaves the enable register alone
    a_r3_read_keeps: assert property (@(posedge clk) disable iff (rst)
        (csr_en && !csr_sel && csr_op == 2'd0) |=> $stable(en_q));
endmodule

bind hart_irq_ctrl hart_irq_ctrl_chk #(.XLEN(XLEN)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .glb_ie     (glb_ie),
    .irq_ext    (irq_ext),
    .csr_en     (csr_en),
    .csr_op     (csr_op),
    .csr_sel    (csr_sel),
    .trap_ack   (trap_ack),
    .trap_req   (trap_req),
    .en_q       (en_q),
    .pend_q     (pend_q),
    .trap_cause (trap_cause)
);

// File: tb/hart_irq_ctrl_tb_top.sv
module hart_irq_ctrl_tb_top;
    localparam int XLEN = 32;
    localparam logic [9:0] MASK = 10'h222;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            glb_ie = 1'b0;
    logic            irq_sw = 1'b0, irq_tmr = 1'b0, irq_ext = 1'b0;
    logic            csr_en = 1'b0;
    logic [1:0]      csr_op = 2'd0;
    logic            csr_sel = 1'b0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [XLEN-1:0] csr_rdata;
    logic            trap_ack = 1'b0;
    logic            trap_req;
    logic [XLEN-1:0] trap_cause;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [9:0]      m_en = '0, m_pend = '0;
    logic [XLEN-1:0] m_cause = '0;

    always #5 clk = ~clk;

    hart_irq_ctrl #(.XLEN(XLEN)) dut_i (
        .clk(clk), .rst(rst), .glb_ie(glb_ie),
        .irq_sw(irq_sw), .irq_tmr(irq_tmr), .irq_ext(irq_ext),
        .csr_en(csr_en), .csr_op(csr_op), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .trap_ack(trap_ack), .trap_req(trap_req), .trap_cause(trap_cause)
    );

    function automatic logic [3:0] exp_code(logic [9:0] en, logic [9:0] pend);
        logic [9:0] l = en & pend;
        if (l[9]) return 4'd9;
        if (l[1]) return 4'd1;
        if (l[5]) return 4'd5;
        return 4'd0;
    endfunction

    function automatic logic exp_req(logic [9:0] en, logic [9:0] pend, logic g);
        return g && ((en & pend) != 10'd0);
    endfunction

    task automatic check(string tag, logic [XLEN-1:0] got, logic [XLEN-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Inputs are already set after a falling edge; check, then cross one rising edge
    task automatic step();
        logic [9:0] opnd;
        logic       req;
        #1;
        req = exp_req(m_en, m_pend, glb_ie);
        check("R5 trap_req", {31'd0, trap_req}, {31'd0, req});
        check(csr_sel ? "R4 pending read" : "R2 enable read", csr_rdata,
              {22'd0, (csr_sel ? m_pend : m_en)});
        check("R7 cause hold/load", trap_cause, m_cause);
        opnd = csr_wdata[9:0] & MASK;
        if (trap_ack && req) m_cause = {1'b1, 27'd0, exp_code(m_en, m_pend)};
        if (csr_en && !csr_sel) begin
            case (csr_op)
                2'd1: m_en = opnd;
                2'd2: m_en = m_en | opnd;
                2'd3: m_en = m_en & ~opnd;
                default: ;
            endcase
        end
        m_pend = '0;
        m_pend[1] = irq_sw; m_pend[5] = irq_tmr; m_pend[9] = irq_ext;
        @(negedge clk);
    endtask

    task automatic csr(logic [1:0] op, logic sel, logic [XLEN-1:0] d);
        csr_en = 1'b1; csr_op = op; csr_sel = sel; csr_wdata = d;
        step();
        csr_en = 1'b0; csr_op = 2'd0; csr_sel = 1'b0; csr_wdata = '0;
    endtask

    initial begin
        int seed = 32'h5eed_1234;
        void'($urandom(seed));
        irq_sw = 1'b1; irq_ext = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        irq_sw = 1'b0; irq_ext = 1'b0;
        #1;
        // R1 reset state
        check("R1 trap_req", {31'd0, trap_req}, 32'd0);
        check("R1 cause", trap_cause, 32'd0);
        check("R1 enable", csr_rdata, 32'd0);
        csr_sel = 1'b1; #1;
        check("R1 pending", csr_rdata, 32'd0);
        csr_sel = 1'b0;
        @(negedge clk);

        // R2 write is masked to the three live bits
        csr(2'd1, 1'b0, 32'hFFFF_FFFF);
        #1 check("R2 masked write", csr_rdata, 32'h222);
        // R3 set / clear / read
        csr(2'd1, 1'b0, 32'h20);
        csr(2'd2, 1'b0, 32'h200);
        #1 check("R3 set", csr_rdata, 32'h220);
        csr(2'd3, 1'b0, 32'h20);
        #1 check("R3 clear", csr_rdata, 32'h200);
        csr(2'd0, 1'b0, 32'h222);
        #1 check("R3 read no change", csr_rdata, 32'h200);
        // R4 pending ignores writes
        irq_tmr = 1'b1;
        step();
        csr(2'd1, 1'b1, 32'h0);
        csr_sel = 1'b1; #1;
        check("R4 pending after write", csr_rdata, 32'h20);
        csr_sel = 1'b0;
        @(negedge clk);

        // R5 global enable gates the request
        csr(2'd1, 1'b0, 32'h222);
        irq_tmr = 1'b1; irq_sw = 1'b1; irq_ext = 1'b1;
        step();
        #1 check("R5 gie low blocks", {31'd0, trap_req}, 32'd0);
        @(negedge clk);

        // R6 priority walk
        glb_ie = 1'b1; trap_ack = 1'b1;
        step();
        check("R6 external first", trap_cause, 32'h8000_0009);
        irq_ext = 1'b0;
        step();
        step();
        check("R6 software second", trap_cause, 32'h8000_0001);
        irq_sw = 1'b0;
        step();
        step();
        check("R6 timer last", trap_cause, 32'h8000_0005);
        // R7 hold when no request
        irq_tmr = 1'b0;
        step();
        step();
        check("R7 hold without request", trap_cause, 32'h8000_0005);

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            glb_ie   = ($urandom % 4) != 0;
            irq_sw   = $urandom % 2;
            irq_tmr  = $urandom % 2;
            irq_ext  = ($urandom % 3) == 0;
            trap_ack = $urandom % 2;
            csr_en   = ($urandom % 4) == 0;
            csr_op   = 2'($urandom % 4);
            csr_sel  = $urandom % 2;
            csr_wdata = $urandom;
            step();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule